// File: doc/BRIEF.md
# Branch Outcome Predictor Table

This block sits beside the fetch stage and guesses, each cycle, where fetch should go next. It looks up the current fetch address in a small direct-mapped table. Each table slot remembers whether the branch that last used that slot was taken. If the fetched instruction is a branch and the guess is "taken", the block returns the fetch address plus the branch offset. In every other case it returns the fetch address plus four.

A slot that has never been written carries no history. For such a slot the guess comes from the sign of the offset. A backward jump (negative offset) is guessed taken, which suits loops. A forward jump is guessed not taken.

Later in the pipeline the branch resolves. The resolution port then writes the real outcome into the slot that the branch address maps to. When the resolving stage reports that the earlier guess was wrong, the block raises a flush and supplies the correct address to restart fetch.

Top module: `branch_guess_table`

## Requirements
- R1: After reset every slot is empty. A branch that maps to an empty slot takes its guess from the offset sign alone.
- R2: For a branch with an empty slot and a negative offset (bit PC_W-1 set), `predTaken` is 1.
- R3: For a branch with an empty slot and a zero or positive offset, `predTaken` is 0.
- R4: Once a slot has been written, a branch mapping to it is guessed with the stored outcome, whatever the offset sign.
- R5: `predNextPc` equals `fetchPc + fetchOffset` when `predTaken` is 1, and `fetchPc + 4` otherwise (modulo 2^PC_W).
- R6: When `fetchIsBranch` is 0, `predTaken` is 0 and `predNextPc` equals `fetchPc + 4`.
- R7: The slot index is the address bits [IDX_W+1:2]. Two addresses that differ only above those bits, or only in bits [1:0], share a slot. Two addresses that differ inside those bits do not.
- R8: When a lookup and an update hit the same slot in the same cycle, the lookup sees the contents from before the update. The new contents become visible on the next cycle.
- R9: `flush` is 1 exactly when `resValid` and `resMispredict` are both 1. While `flush` is 1, `redirectPc` is `resTarget` if `resTaken` is 1, and `resPc + 4` if it is 0.
- R10: While `resValid` is 0, the values on `resPc`, `resTaken` and `resTarget` leave every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties all slots |
| fetchPc | input | PC_W | Address being fetched |
| fetchIsBranch | input | 1 | The fetched instruction is a conditional branch |
| fetchOffset | input | PC_W | Sign-extended branch offset of the fetched instruction |
| predTaken | output | 1 | Guess that the branch is taken |
| predNextPc | output | PC_W | Guessed next fetch address |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | PC_W | Address of the resolving branch |
| resTaken | input | 1 | Real outcome of the resolving branch |
| resTarget | input | PC_W | Computed target of the resolving branch |
| resMispredict | input | 1 | The earlier guess for this branch was wrong |
| flush | output | 1 | Discard younger instructions and restart fetch |
| redirectPc | output | PC_W | Restart address when `flush` is 1 |

## Verification
The assertions assume that `resValid` and its companion fields are driven to known values in every cycle after reset. They also assume that the resolution port never reports more than one branch per cycle. The bench drives every input at the falling edge, so each cycle sees a single, settled resolution. The bench picks fetch and resolve addresses from a small pool, so that aliasing and same-slot collisions happen often. The bench sets `resMispredict` on its own, without tying it to any earlier guess. This is allowed, because the block's only duty on that input is to turn it into a flush.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
  // Strobes the control half hands to the table datapath each cycle.
  typedef struct packed {
    logic wrEn;       // commit a resolved outcome to its slot
    logic wrTaken;    // outcome value to store
    logic useOffset;  // next fetch uses the branch offset
    logic redirTaken; // restart address is the resolved target
  } bgtStrobes_t;
endpackage

// File: rtl/bgt_datapath.sv
module bgt_datapath
  import bgt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   fetchOffset,
  input  logic [PC_W-1:0]   resPc,
  input  logic [PC_W-1:0]   resTarget,
  input  bgtStrobes_t       strobes,
  output logic              lookupValid,
  output logic              lookupTaken,
  output logic [PC_W-1:0]   predNextPc,
  output logic [PC_W-1:0]   redirectPc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [IDX_W-1:0]   rdIdx, wrIdx;
  logic [ENTRIES-1:0] validQ, takenQ;

  // word-aligned instructions: skip the two byte-offset bits
  assign rdIdx = fetchPc[IDX_W+1:2];
  assign wrIdx = resPc[IDX_W+1:2];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic hitWr;
    assign hitWr = strobes.wrEn && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validQ[e] <= 1'b0;
        takenQ[e] <= 1'b0;
      end else if (hitWr) begin
        validQ[e] <= 1'b1;
        takenQ[e] <= strobes.wrTaken;
      end
    end

    // a slot once filled is only emptied by reset
    assert_slot_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      validQ[e] |=> validQ[e]);
  end

  // read returns the registered contents: same-cycle writes are not visible
  assign lookupValid = validQ[rdIdx];
  assign lookupTaken = takenQ[rdIdx];

  assign predNextPc = fetchPc + (strobes.useOffset ? fetchOffset : STEP);
  assign redirectPc = strobes.redirTaken ? resTarget : (resPc + STEP);

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrEn |=> (validQ[$past(wrIdx)] && (takenQ[$past(wrIdx)] == $past(strobes.wrTaken))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrEn |=> ($stable(validQ) && $stable(takenQ)));
endmodule

// File: rtl/bgt_ctrl.sv
module bgt_ctrl
  import bgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetchIsBranch,
  input  logic        offsetNeg,
  input  logic        lookupValid,
  input  logic        lookupTaken,
  input  logic        resValid,
  input  logic        resTaken,
  input  logic        resMispredict,
  output bgtStrobes_t strobes,
  output logic        predTaken,
  output logic        flush
);
  logic guess;

  // stored history wins; an empty slot falls back to the offset sign
  always_comb begin
    if (!fetchIsBranch)   guess = 1'b0;
    else if (lookupValid) guess = lookupTaken;
    else                  guess = offsetNeg;
  end

  always_comb begin
    strobes.wrEn       = resValid;
    strobes.wrTaken    = resTaken;
    strobes.useOffset  = guess;
    strobes.redirTaken = resTaken;
  end

  assign predTaken = guess;
  assign flush     = resValid & resMispredict;

  assert_no_spurious_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> !flush);
endmodule

// File: rtl/branch_guess_table.sv
module branch_guess_table
  import bgt_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            fetchIsBranch,
  input  logic [PC_W-1:0] fetchOffset,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resTarget,
  input  logic            resMispredict,
  output logic            flush,
  output logic [PC_W-1:0] redirectPc
);
  localparam int IDX_W = $clog2(ENTRIES);

  bgtStrobes_t strobes;
  logic        lookupValid, lookupTaken;

  bgt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetchIsBranch(fetchIsBranch), .offsetNeg(fetchOffset[PC_W-1]),
    .lookupValid(lookupValid), .lookupTaken(lookupTaken),
    .resValid(resValid), .resTaken(resTaken), .resMispredict(resMispredict),
    .strobes(strobes), .predTaken(predTaken), .flush(flush)
  );

  bgt_datapath #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .fetchPc(fetchPc), .fetchOffset(fetchOffset),
    .resPc(resPc), .resTarget(resTarget), .strobes(strobes),
    .lookupValid(lookupValid), .lookupTaken(lookupTaken),
    .predNextPc(predNextPc), .redirectPc(redirectPc)
  );

  assert_plain_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchIsBranch |-> (!predTaken && predNextPc == fetchPc + PC_W'(4)));
endmodule

// File: tb/sim_branch_guess_table.sv
`timescale 1ns/1ps
module sim_branch_guess_table;
  localparam int PC_W = 32;
  localparam int ENTRIES = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] fetchPc = '0, fetchOffset = '0, resPc = '0, resTarget = '0;
  logic fetchIsBranch = 1'b0, resValid = 1'b0, resTaken = 1'b0, resMispredict = 1'b0;
  logic predTaken, flush;
  logic [PC_W-1:0] predNextPc, redirectPc;

  int checks = 0, errors = 0;
  bit done = 0;
  bit refV [ENTRIES];
  bit refT [ENTRIES];

  always #4 clk = ~clk;

  branch_guess_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u0 (.*);

  function automatic int slotOf(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic bit expGuess(logic [PC_W-1:0] pc, bit br, logic [PC_W-1:0] off);
    if (!br) return 1'b0;
    if (refV[slotOf(pc)]) return refT[slotOf(pc)];
    return off[PC_W-1];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, compare against the model, then commit
  task automatic step(logic [PC_W-1:0] pc, bit br, logic [PC_W-1:0] off,
                      bit rv, logic [PC_W-1:0] rpc, bit rt, logic [PC_W-1:0] rtg, bit rm,
                      string req);
    bit eg;
    logic [PC_W-1:0] en;
    @(negedge clk);
    fetchPc = pc; fetchIsBranch = br; fetchOffset = off;
    resValid = rv; resPc = rpc; resTaken = rt; resTarget = rtg; resMispredict = rm;
    #1;
    eg = expGuess(pc, br, off);
    en = eg ? pc + off : pc + 4;
    chk(predTaken == eg, req, "predTaken", {31'b0, predTaken}, {31'b0, eg});
    chk(predNextPc == en, "R5", "predNextPc", predNextPc, en);
    chk(flush == (rv && rm), "R9", "flush", {31'b0, flush}, {31'b0, rv && rm});
    if (rv && rm)
      chk(redirectPc == (rt ? rtg : rpc + 4), "R9", "redirectPc", redirectPc, rt ? rtg : rpc + 4);
    @(posedge clk);
    if (rv) begin refV[slotOf(rpc)] = 1'b1; refT[slotOf(rpc)] = rt; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pool [8];
    logic [PC_W-1:0] back, fwd;
    int unused;
    unused = $urandom(32'd2024);
    back = 32'hFFFF_FFF0; fwd = 32'h0000_0040;
    for (int i = 0; i < ENTRIES; i++) begin refV[i] = 0; refT[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2 / R3: empty table falls back to offset sign
    step(32'h1000, 1, back, 0, 0, 0, 0, 0, "R2");
    chk(predTaken == 1'b1, "R1", "post-reset backward guess", {31'b0, predTaken}, 32'd1);
    step(32'h1004, 1, fwd, 0, 0, 0, 0, 0, "R3");
    chk(predTaken == 1'b0, "R3", "forward guess", {31'b0, predTaken}, 32'd0);
    // R6: non-branch with backward offset still sequential
    step(32'h1008, 0, back, 0, 0, 0, 0, 0, "R6");
    chk(predNextPc == 32'h100C, "R6", "plain next", predNextPc, 32'h100C);

    // R8: same-cycle update of slot of 0x1004 returns old (not taken)
    step(32'h1004, 1, fwd, 1, 32'h1004, 1, 32'h1044, 1, "R8");
    chk(predTaken == 1'b0, "R8", "old value on collision", {31'b0, predTaken}, 32'd0);
    // R4: now stored taken overrides forward offset
    step(32'h1004, 1, fwd, 0, 0, 0, 0, 0, "R4");
    chk(predTaken == 1'b1, "R4", "stored taken", {31'b0, predTaken}, 32'd1);
    chk(predNextPc == 32'h1044, "R5", "taken target", predNextPc, 32'h1044);
    // R7: alias ENTRIES*4 above shares slot, low bits ignored; neighbour slot differs
    step(32'h1004 + ENTRIES*4 + 2, 1, fwd, 0, 0, 0, 0, 0, "R7");
    chk(predTaken == 1'b1, "R7", "alias shares slot", {31'b0, predTaken}, 32'd1);
    step(32'h1008, 1, fwd, 0, 0, 0, 0, 0, "R7");
    chk(predTaken == 1'b0, "R7", "neighbour slot empty", {31'b0, predTaken}, 32'd0);

    // R10: idle resolve fields do not write
    step(32'h1000, 1, back, 0, 32'h1000, 0, 32'hDEAD_BEE0, 1, "R10");
    step(32'h1000, 1, back, 0, 0, 0, 0, 0, "R10");
    chk(predTaken == 1'b1, "R10", "slot untouched", {31'b0, predTaken}, 32'd1);
    // R4: stored not-taken overrides backward offset
    step(32'h1000, 1, back, 1, 32'h1000, 0, 32'h0FF0, 1, "R9");
    chk(redirectPc == 32'h1004 && flush, "R9", "redirect fallthrough", redirectPc, 32'h1004);
    step(32'h1000, 1, back, 0, 0, 0, 0, 0, "R4");
    chk(predTaken == 1'b0, "R4", "stored not-taken", {31'b0, predTaken}, 32'd0);

    // reset empties again
    @(negedge clk); rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin refV[i] = 0; refT[i] = 0; end
    step(32'h1000, 1, back, 0, 0, 0, 0, 0, "R1");
    chk(predTaken == 1'b1, "R1", "reset clears history", {31'b0, predTaken}, 32'd1);

    // looping traces with random outcomes over a small aliasing pool
    for (int i = 0; i < 8; i++) pool[i] = 32'h2000 + 32'(($urandom % 40) * 4);
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] p, rp, off;
      bit rv;
      p  = pool[$urandom % 8];
      rp = pool[$urandom % 8];
      off = ($urandom % 2) ? -32'(($urandom % 64 + 1) * 4) : 32'(($urandom % 64) * 4);
      rv = ($urandom % 3) != 0;
      step(p, ($urandom % 4) != 0, off, rv, rp, $urandom % 2, $urandom, $urandom % 2, "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule